// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block turns a group of general-purpose input pins into one shared interrupt request. Each pin is brought into the clock domain through a two-stage synchroniser. Its own detection mode then decides whether the pin is watched for a rising edge, a falling edge, either edge, a high level or a low level. When a detected event occurs on an enabled pin, a sticky pending bit is set. The interrupt output is raised whenever any pending bit is not masked.

Software reaches the block through a small word-addressed register bus with a combinational read path. It writes the per-pin mode codes and sets the enable bits. On an interrupt it reads the status word and acknowledges each set bit by writing a one to it. Masking uses a pair of write-one registers, one that sets mask bits and one that clears them, so no read-modify-write is needed. Both of these addresses read back the current mask.

Register word addresses: 0 enable (read/write), 1 mask-set (write) / mask (read), 2 mask-clear (write) / mask (read), 3 status (read-only), 4 acknowledge (write, reads 0), 5 mode word for pins 0–7, 6 mode word for pins 8–15, 7 reads 0.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After a synchronous reset the enable, mask, status and mode words all read 0, and `irq_o` is 0.
- R2: Mode code 1 sets the pending bit on a rising edge, code 0 on a falling edge, and code 4 on either edge, each once per edge.
- R3: Mode code 2 (low) and code 3 (high) set the pending bit on every cycle the level is active, so an acknowledge during the active level leaves the bit set.
- R4: The mode of pin p sits in bits [4k+2:4k] with k = p mod 8, in word 5 for p < 8 and in word 6 otherwise. Bit 4k+3 always reads 0. Codes 5, 6 and 7 never produce an event.
- R5: Writing 1 to bit p of the acknowledge word clears pending bit p, and 0 bits leave it unchanged. If an event on pin p occurs in the same cycle as its acknowledge, the bit stays set.
- R6: A 1 in bit p of a mask-set write sets mask bit p, a 1 in a mask-clear write clears it, and 0 bits leave the mask unchanged. The mask reads back at words 1 and 2.
- R7: The status word holds pending bit p at bit position p. Every bit at or above the pin count, in every word, reads 0.
- R8: The enable word is read/write with one bit per pin. A pin whose enable bit is 0 never sets its pending bit.
- R9: `irq_o` is registered. In each cycle it equals the OR over all pins of (pending AND NOT mask) from the cycle before.
- R10: A pin change applied before clock edge k becomes visible in the status word after edge k+2 and on `irq_o` after edge k+3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NPINS | Asynchronous GPIO pin levels |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Shared active-high interrupt request |

## Verification
Some properties are checked by assertions on every cycle: that the output follows the unmasked pending set, that a pending bit never rises on a disabled pin, that an acknowledge clears only bits with no simultaneous event, that a simultaneous event keeps the bit set, that mask writes take effect, and that unused upper bits read as 0. Other behaviours need the bench's scenarios, because they depend on ordered pin sequences and on comparing readback with a reference model. These are the exact latency through the synchroniser, the difference between edge modes and level modes, the nibble placement of the mode codes, and the silence of codes 5 to 7.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 3;
    localparam int MODE_W   = 3;
    localparam int SLOT_W   = 4;
    localparam int PER_WORD = DATA_W / SLOT_W;

    typedef logic [MODE_W-1:0] mode_t;

    typedef enum logic [MODE_W-1:0] {
        DET_FALL = 3'd0,
        DET_RISE = 3'd1,
        DET_LOW  = 3'd2,
        DET_HIGH = 3'd3,
        DET_BOTH = 3'd4
    } det_mode_e;

    typedef enum logic [ADDR_W-1:0] {
        A_ENABLE  = 3'd0,
        A_MASKSET = 3'd1,
        A_MASKCLR = 3'd2,
        A_STATUS  = 3'd3,
        A_ACK     = 3'd4,
        A_MODE_LO = 3'd5,
        A_MODE_HI = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic enable;
        logic mask_set;
        logic mask_clr;
        logic ack;
        logic mode_lo;
        logic mode_hi;
    } wr_dec_t;

    function automatic wr_dec_t decode_write(logic we, logic [ADDR_W-1:0] addr);
        wr_dec_t d;
        d.enable   = we && (addr == A_ENABLE);
        d.mask_set = we && (addr == A_MASKSET);
        d.mask_clr = we && (addr == A_MASKCLR);
        d.ack      = we && (addr == A_ACK);
        d.mode_lo  = we && (addr == A_MODE_LO);
        d.mode_hi  = we && (addr == A_MODE_HI);
        return d;
    endfunction

    function automatic logic pin_event(mode_t mode, logic cur, logic prv);
        case (mode)
            DET_FALL: return prv & ~cur;
            DET_RISE: return cur & ~prv;
            DET_LOW:  return ~cur;
            DET_HIGH: return cur;
            DET_BOTH: return cur ^ prv;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] q_prev
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign q      = sync_q;
    assign q_prev = hist_q;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 12
) (
    input  logic [NPINS-1:0]             cur,
    input  logic [NPINS-1:0]             prev,
    input  logic [NPINS-1:0][MODE_W-1:0] modes,
    input  logic [NPINS-1:0]             enable,
    output logic [NPINS-1:0]             evt
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        assign evt[p] = enable[p] & pin_event(modes[p], cur[p], prev[p]);
    end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 12
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bus_we,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    input  logic [NPINS-1:0]             evt,
    output logic [NPINS-1:0]             enable,
    output logic [NPINS-1:0]             mask,
    output logic [NPINS-1:0]             pending,
    output logic [NPINS-1:0][MODE_W-1:0] modes
);
    wr_dec_t          wr;
    logic [NPINS-1:0] wbits;
    logic [NPINS-1:0] ack_bits;
    logic [NPINS-1:0] en_q, mask_q, pend_q;
    logic [NPINS-1:0][MODE_W-1:0] mode_q;
    logic [DATA_W-1:0] mode_lo_w, mode_hi_w;

    assign wr       = decode_write(bus_we, bus_addr);
    assign wbits    = bus_wdata[NPINS-1:0];
    assign ack_bits = wr.ack ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            mask_q <= '0;
            pend_q <= '0;
        end else begin
            if (wr.enable)   en_q <= wbits;
            if (wr.mask_set) mask_q <= mask_q | wbits;
            if (wr.mask_clr) mask_q <= mask_q & ~wbits;
            pend_q <= (pend_q & ~ack_bits) | evt;
        end
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_mode
        localparam int SLOT = p % PER_WORD;
        localparam bit HIGH = (p >= PER_WORD);
        always_ff @(posedge clk) begin
            if (rst) begin
                mode_q[p] <= '0;
            end else if (HIGH ? wr.mode_hi : wr.mode_lo) begin
                mode_q[p] <= bus_wdata[SLOT*SLOT_W +: MODE_W];
            end
        end
    end

    always_comb begin
        mode_lo_w = '0;
        mode_hi_w = '0;
        for (int p = 0; p < NPINS; p++) begin
            if (p < PER_WORD) mode_lo_w[(p % PER_WORD)*SLOT_W +: MODE_W] = mode_q[p];
            else              mode_hi_w[(p % PER_WORD)*SLOT_W +: MODE_W] = mode_q[p];
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_ENABLE:            bus_rdata = DATA_W'(en_q);
            A_MASKSET, A_MASKCLR: bus_rdata = DATA_W'(mask_q);
            A_STATUS:            bus_rdata = DATA_W'(pend_q);
            A_MODE_LO:           bus_rdata = mode_lo_w;
            A_MODE_HI:           bus_rdata = mode_hi_w;
            default:             bus_rdata = '0;
        endcase
    end

    assign enable  = en_q;
    assign mask    = mask_q;
    assign pending = pend_q;
    assign modes   = mode_q;

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        wr.ack |=> ((pend_q & $past(wbits & ~evt)) == '0)); // R5
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((pend_q & $past(evt)) == $past(evt))); // R5
    AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
        wr.mask_set |=> ((mask_q & $past(wbits)) == $past(wbits))); // R6
    AST_MASK_CLR: assert property (@(posedge clk) disable iff (rst)
        wr.mask_clr |=> ((mask_q & $past(wbits)) == '0)); // R6
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != A_MODE_LO && bus_addr != A_MODE_HI) |->
            (bus_rdata[DATA_W-1:NPINS] == '0)); // R7

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPINS-1:0]  pin_i,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    // NPINS may range from 1 to 2*PER_WORD (two mode words).
    logic [NPINS-1:0] pin_cur, pin_prev, evt, enable, mask, pending;
    logic [NPINS-1:0][MODE_W-1:0] modes;
    logic irq_q;

    gpio_irq_sync #(.WIDTH(NPINS)) i_sync (
        .clk(clk), .rst(rst), .d(pin_i), .q(pin_cur), .q_prev(pin_prev)
    );

    gpio_irq_detect #(.NPINS(NPINS)) i_detect (
        .cur(pin_cur), .prev(pin_prev), .modes(modes), .enable(enable), .evt(evt)
    );

    gpio_irq_regs #(.NPINS(NPINS)) i_regs (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt(evt),
        .enable(enable), .mask(mask), .pending(pending), .modes(modes)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(pending & ~mask);
    end

    assign irq_o = irq_q;

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((pending & ~mask) == '0) |=> !irq_o); // R9
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past((pending & ~mask) != '0)); // R9
    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
        ((pending & ~$past(pending) & ~$past(enable)) == '0)); // R8

endmodule

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
    localparam int N = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] pins = '0;
    logic        we = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    gpio_irq_ctrl #(.NPINS(N)) i_gpio_irq_ctrl (
        .clk(clk), .rst(rst), .pin_i(pins), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
    );

    // Behavioural reference model
    logic [N-1:0] m_s1, m_s2, m_pv, m_pend, m_en, m_mask;
    int           m_mode [N];
    bit           m_irq;

    function automatic logic [31:0] model_read(logic [2:0] a);
        logic [31:0] r = '0;
        case (a)
            3'd0: r = 32'(m_en);
            3'd1, 3'd2: r = 32'(m_mask);
            3'd3: r = 32'(m_pend);
            3'd5: for (int p = 0; p < 8; p++) r |= 32'(m_mode[p]) << (4*p);
            3'd6: for (int p = 8; p < N; p++) r |= 32'(m_mode[p]) << (4*(p-8));
            default: r = '0;
        endcase
        return r;
    endfunction

    always @(posedge clk) begin
        logic [N-1:0] ev, ack;
        bit nirq;
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_pv = '0; m_pend = '0; m_en = '0; m_mask = '0;
            m_irq = 0;
            for (int p = 0; p < N; p++) m_mode[p] = 0;
        end else begin
            ev = '0;
            for (int p = 0; p < N; p++) begin
                bit c, v, e;
                c = m_s2[p]; v = m_pv[p];
                case (m_mode[p])
                    0: e = v && !c;
                    1: e = c && !v;
                    2: e = !c;
                    3: e = c;
                    4: e = (c != v);
                    default: e = 0;
                endcase
                ev[p] = e && m_en[p];
            end
            ack  = (we && addr == 3'd4) ? wdata[N-1:0] : '0;
            nirq = |(m_pend & ~m_mask);
            m_pend = (m_pend & ~ack) | ev;
            if (we) begin
                case (addr)
                    3'd0: m_en = wdata[N-1:0];
                    3'd1: m_mask = m_mask | wdata[N-1:0];
                    3'd2: m_mask = m_mask & ~wdata[N-1:0];
                    3'd5: for (int p = 0; p < 8; p++) m_mode[p] = int'((wdata >> (4*p)) & 32'h7);
                    3'd6: for (int p = 8; p < N; p++) m_mode[p] = int'((wdata >> (4*(p-8))) & 32'h7);
                    default: ;
                endcase
            end
            m_pv = m_s2; m_s2 = m_s1; m_s1 = pins;
            m_irq = nirq;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        if (!rst && !done) begin
            check("R9 irq_o vs model", 32'(irq), 32'(m_irq));
            if (!we) check("R7 readback vs model", rdata, model_read(addr));
        end
    end

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0; wdata = '0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk); we = 1'b0; addr = a;
        @(posedge clk); #2; d = rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8*150000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reset register", v, 32'h0);
        end
        check("R1 reset irq", 32'(irq), 32'h0);

        // R4 mode layout, reserved bit 3 and missing pins read 0
        wr(3'd5, 32'h00D3AC09);
        rd(3'd5, v); check("R4 mode low word", v, 32'h00532401);
        wr(3'd6, 32'hFFFFC0B9);
        rd(3'd6, v); check("R4 R7 mode high word", v, 32'h00004031);

        // R8 disabled pin ignores edge
        pins[0] = 1'b1;
        idle(5);
        rd(3'd3, v); check("R8 disabled pin status", v, 32'h0);
        pins[0] = 1'b0;
        idle(5);

        // R8 enable readback, upper bits zero
        wr(3'd0, 32'hFFFFFFFF);
        rd(3'd0, v); check("R8 R7 enable readback", v, 32'h00000FFF);
        // level-low pins: pin3 (code 2); pins 1,6,7,10 are falling-edge, pin5 code 5
        idle(3);
        rd(3'd3, v); check("R3 level low pending", v & 32'h8, 32'h8);
        wr(3'd4, 32'h8);
        rd(3'd3, v); check("R3 ack during active level", v & 32'h8, 32'h8);

        // R10 latency on pin 8 (rising)
        @(negedge clk); addr = 3'd3; pins[8] = 1'b1;
        @(posedge clk); @(posedge clk); #2;
        check("R10 not yet pending after two edges", rdata & 32'h100, 32'h0);
        @(posedge clk); #2;
        check("R10 pending after third edge", rdata & 32'h100, 32'h100);
        @(posedge clk); #2;
        check("R10 R9 irq after fourth edge", 32'(irq), 32'h1);

        // R2 rising edge on pin0
        pins[0] = 1'b1;
        idle(5);
        rd(3'd3, v); check("R2 rising edge pending", v & 32'h1, 32'h1);
        // R5 zero bits no effect, then clear
        wr(3'd4, 32'h0);
        rd(3'd3, v); check("R5 ack zero bits", v & 32'h101, 32'h101);
        wr(3'd4, 32'h1);
        rd(3'd3, v); check("R5 ack clears bit0", v & 32'h1, 32'h0);
        pins[0] = 1'b0;
        idle(5);
        rd(3'd3, v); check("R2 falling ignored in rise mode", v & 32'h1, 32'h0);

        // R4 code 5 on pin5 never fires
        pins[5] = 1'b1; idle(5); pins[5] = 1'b0; idle(5);
        rd(3'd3, v); check("R4 code 5 silent", v & 32'h20, 32'h0);

        // R2 both edges on pin2 and R5 event wins over same-cycle ack
        wr(3'd4, 32'h4);
        @(negedge clk); pins[2] = 1'b1;
        @(posedge clk); @(posedge clk);
        wr(3'd4, 32'h4);
        rd(3'd3, v); check("R5 event wins over ack", v & 32'h4, 32'h4);
        wr(3'd4, 32'h4);
        pins[2] = 1'b0;
        idle(5);
        rd(3'd3, v); check("R2 both-edge falling", v & 32'h4, 32'h4);

        // R6 mask set/clear and effect on irq
        wr(3'd1, 32'hFFFFFFFF);
        rd(3'd1, v); check("R6 mask set readback", v, 32'h00000FFF);
        idle(2);
        check("R6 R9 masked irq low", 32'(irq), 32'h0);
        wr(3'd2, 32'h00000008);
        rd(3'd2, v); check("R6 mask clear readback", v, 32'h00000FF7);
        idle(2);
        check("R9 unmasked level pin raises irq", 32'(irq), 32'h1);
        wr(3'd1, 32'h0);
        rd(3'd1, v); check("R6 zero set bits no effect", v, 32'h00000FF7);

        // Random phase checked against model every cycle
        wr(3'd2, 32'hFFF);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            pins = N'($urandom);
            case ($urandom % 6)
                0: begin we = 1'b1; addr = 3'd4; wdata = $urandom; end
                1: begin we = 1'b1; addr = 3'($urandom % 3); wdata = $urandom; end
                2: begin we = 1'b1; addr = 3'(5 + $urandom % 2); wdata = $urandom; end
                default: begin we = 1'b0; addr = 3'($urandom % 8); end
            endcase
        end
        @(negedge clk); we = 1'b0;
        idle(4);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule